// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block steps through a ring of transmit descriptors kept in shared memory, using a single 32-bit read/write bus master port. Each descriptor is eight bytes long. The status word comes first and carries the frame length in its upper half and control flags in its lower half. The buffer address follows in the next word. The walker reads the status word of the current slot. When software has handed that slot to hardware, the walker also reads the buffer address and starts the downstream transmit engine with the address, the length and the per-frame flags. When the engine reports that it has finished, the walker writes the status word back with ownership returned to software. It then moves to the next slot, or back to slot 0 after a slot marked as the last one.

No count register exists. Ownership and the end of the ring are both coded inside each status word. While the current slot is not owned by hardware, the walker waits a fixed number of idle cycles and then reads the same slot again. An error response on any bus access stops the walker until the enable input is dropped. The walker is driven by nine named states:

- OFF: idle while disabled.
- RD_STAT: reads the status word.
- POLL_WAIT: the idle gap before a re-read.
- RD_PTR: reads the buffer address.
- LAUNCH: the start pulse.
- IN_FLIGHT: waits for the engine.
- WRITE_BACK: writes the status word.
- RETIRE: advances the index and raises the completion pulse.
- FAULT: halted after an error.

The transitions between these states are:

- OFF→RD_STAT when enabled.
- RD_STAT→RD_PTR when the slot is owned by hardware, and RD_STAT→POLL_WAIT when it is not.
- POLL_WAIT→RD_STAT when the timer expires, and POLL_WAIT→OFF when disabled.
- RD_PTR→LAUNCH on the response.
- LAUNCH→IN_FLIGHT.
- IN_FLIGHT→WRITE_BACK on engine completion.
- WRITE_BACK→RETIRE on the response.
- RETIRE→RD_STAT, or RETIRE→OFF when disabled.
- RD_STAT, RD_PTR or WRITE_BACK→FAULT on a bus error.
- FAULT→OFF when disabled.

Top module: `txbd_ring_walker`

## Requirements
- R1: After reset, and while `enable` is low, `bus_req`, `tx_start`, `done_pulse` and `fault` are all low. The first access after `enable` rises is a read of slot 0 at `RING_BASE`.
- R2: Slot n has its status word at `RING_BASE + 8n` and its buffer address at `RING_BASE + 8n + 4`.
- R3: A status word with bit 15 clear (not owned by hardware) starts no frame. The same slot is read again after exactly `POLL_GAP` cycles with `bus_req` low.
- R4: For an owned slot, `tx_start` is a one-cycle pulse. During that pulse, `tx_buf_ptr` equals the buffer address word, `tx_len` equals status bits 31:16, and `tx_irq_req`, `tx_pad` and `tx_crc` equal status bits 14, 12 and 11. These outputs stay stable until `tx_done`.
- R5: After `tx_done`, exactly one write goes to the slot's status address. The data written is the status word read earlier with bit 15 cleared and every other bit unchanged.
- R6: After a slot is released, the next status read is at slot n+1. When status bit 13 (last slot) was set, it is at slot 0 instead.
- R7: One cycle after the write-back is accepted, `done_pulse` is high for one cycle if status bit 14 was set. Otherwise it stays low.
- R8: An error response to any access raises `fault` and stops all bus requests and starts. Dropping `enable` clears `fault`. Raising `enable` again resumes at the same slot.
- R9: While `bus_req` is high and neither `bus_ack` nor `bus_err` has been seen, `bus_req`, `bus_addr`, `bus_we` and `bus_wdata` hold steady.
- R10: With `enable` low, the walker stops at the end of a poll wait or after a release, and then issues no requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Walker run control |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 32 | Byte address of the access |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Access completed |
| bus_err | input | 1 | Access failed |
| tx_start | output | 1 | One-cycle frame start to the engine |
| tx_buf_ptr | output | 32 | Frame buffer address |
| tx_len | output | 16 | Frame length in bytes |
| tx_irq_req | output | 1 | Completion notice requested |
| tx_pad | output | 1 | Padding requested |
| tx_crc | output | 1 | CRC append requested |
| tx_done | input | 1 | Engine finished the frame |
| done_pulse | output | 1 | Released slot had its notice bit set |
| fault | output | 1 | Walker halted by a bus error |

## Verification
A wrong ring index shows up on `bus_addr` at the very next status read after a release, within a few cycles. A corrupted latched status word shows up as a bad `tx_len` or flag at the start pulse, or as a bad write-back word. A poll timer that is off by even one cycle changes the measured idle gap between two reads of a slot that is not owned. A state machine that misses an error response, or leaves the fault state, shows up as a request on the bus during the cycles when it must be silent.

// File: rtl/txbd_pkg.sv
package txbd_pkg;

    // Status word bit positions (software and the engine decode these)
    localparam int RDY_BIT  = 15;
    localparam int IRQ_BIT  = 14;
    localparam int WRAP_BIT = 13;
    localparam int PAD_BIT  = 12;
    localparam int CRC_BIT  = 11;
    localparam int LEN_LSB  = 16;
    localparam int LEN_W    = 16;
    localparam int WORD_W   = 32;
    localparam int DESC_BYTES = 8;
    localparam int PTR_OFFSET = 4;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_RD_STAT,
        ST_POLL_WAIT,
        ST_RD_PTR,
        ST_LAUNCH,
        ST_IN_FLIGHT,
        ST_WRITE_BACK,
        ST_RETIRE,
        ST_FAULT
    } walk_state_e;

endpackage

// File: rtl/txbd_ring_index.sv
module txbd_ring_index
    import txbd_pkg::*;
#(
    parameter logic [31:0] RING_BASE = 32'h0000_0000,
    parameter int          IDX_W     = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        advance,
    input  logic        wrap_last,
    output logic [31:0] stat_addr,
    output logic [31:0] ptr_addr
);

    localparam int SHIFT = $clog2(DESC_BYTES);

    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (advance) begin
            if (wrap_last) begin
                idx <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    always_comb begin
        stat_addr = RING_BASE + (32'(idx) << SHIFT);
        ptr_addr  = stat_addr + 32'(PTR_OFFSET);
    end

    // R6: a release without the last-slot mark moves one slot further on
    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !wrap_last && (idx != '1)) |=>
            (stat_addr == $past(stat_addr) + 32'(DESC_BYTES)));

    // R6: a release of the last slot returns to the ring base
    p_wrap_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && wrap_last) |=> (stat_addr == RING_BASE));

endmodule

// File: rtl/txbd_poll_timer.sv
module txbd_poll_timer #(
    parameter int POLL_GAP = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expire
);

    localparam int CNT_W = (POLL_GAP < 2) ? 1 : $clog2(POLL_GAP + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(POLL_GAP - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= RELOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = (cnt == '0);

    initial begin
        if (POLL_GAP < 1) $error("POLL_GAP must be at least 1");
    end

endmodule

// File: rtl/txbd_walk_fsm.sv
module txbd_walk_fsm
    import txbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [WORD_W-1:0] bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [31:0]       stat_addr,
    input  logic [31:0]       ptr_addr,
    input  logic              tx_done,
    input  logic              poll_expire,
    output logic              bus_req,
    output logic              bus_we,
    output logic [31:0]       bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic              tx_start,
    output logic [WORD_W-1:0] tx_buf_ptr,
    output logic [LEN_W-1:0]  tx_len,
    output logic              tx_irq_req,
    output logic              tx_pad,
    output logic              tx_crc,
    output logic              done_pulse,
    output logic              fault,
    output logic              advance,
    output logic              wrap_last,
    output logic              poll_load
);

    walk_state_e state, nxt;
    logic [WORD_W-1:0] status_q;
    logic [WORD_W-1:0] ptr_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= nxt;
        end
    end

    // Latched descriptor words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            ptr_q    <= '0;
        end else begin
            if (state == ST_RD_STAT && bus_ack) status_q <= bus_rdata;
            if (state == ST_RD_PTR  && bus_ack) ptr_q    <= bus_rdata;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF: begin
                if (enable) nxt = ST_RD_STAT;
            end
            ST_RD_STAT: begin
                if (bus_err)                nxt = ST_FAULT;
                else if (bus_ack)           nxt = bus_rdata[RDY_BIT] ? ST_RD_PTR : ST_POLL_WAIT;
            end
            ST_POLL_WAIT: begin
                if (!enable)                nxt = ST_OFF;
                else if (poll_expire)       nxt = ST_RD_STAT;
            end
            ST_RD_PTR: begin
                if (bus_err)                nxt = ST_FAULT;
                else if (bus_ack)           nxt = ST_LAUNCH;
            end
            ST_LAUNCH:                      nxt = ST_IN_FLIGHT;
            ST_IN_FLIGHT: begin
                if (tx_done)                nxt = ST_WRITE_BACK;
            end
            ST_WRITE_BACK: begin
                if (bus_err)                nxt = ST_FAULT;
                else if (bus_ack)           nxt = ST_RETIRE;
            end
            ST_RETIRE:                      nxt = enable ? ST_RD_STAT : ST_OFF;
            ST_FAULT: begin
                if (!enable)                nxt = ST_OFF;
            end
            default:                        nxt = ST_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        bus_req    = 1'b0;
        bus_we     = 1'b0;
        bus_addr   = stat_addr;
        bus_wdata  = status_q & ~(WORD_W'(1) << RDY_BIT);
        tx_start   = 1'b0;
        tx_buf_ptr = ptr_q;
        tx_len     = status_q[LEN_LSB +: LEN_W];
        tx_irq_req = status_q[IRQ_BIT];
        tx_pad     = status_q[PAD_BIT];
        tx_crc     = status_q[CRC_BIT];
        done_pulse = 1'b0;
        fault      = 1'b0;
        advance    = 1'b0;
        wrap_last  = status_q[WRAP_BIT];
        poll_load  = 1'b0;
        unique case (state)
            ST_OFF:        ;
            ST_RD_STAT: begin
                bus_req   = 1'b1;
                poll_load = bus_ack && !bus_rdata[RDY_BIT];
            end
            ST_POLL_WAIT:  ;
            ST_RD_PTR: begin
                bus_req  = 1'b1;
                bus_addr = ptr_addr;
            end
            ST_LAUNCH:     tx_start = 1'b1;
            ST_IN_FLIGHT:  ;
            ST_WRITE_BACK: begin
                bus_req = 1'b1;
                bus_we  = 1'b1;
            end
            ST_RETIRE: begin
                advance    = 1'b1;
                done_pulse = status_q[IRQ_BIT];
            end
            ST_FAULT:      fault = 1'b1;
            default:       ;
        endcase
    end

    // R9: an outstanding access keeps its request, address, direction and data
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !bus_err) |=>
            (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R4: start lasts a single cycle
    p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    // R4: frame fields held while the engine works
    p_fields_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start || (state == ST_IN_FLIGHT && !tx_done)) |=>
            ($stable(tx_buf_ptr) && $stable(tx_len) && $stable(tx_pad) && $stable(tx_crc)));

    // R5: a written status word never claims hardware ownership
    p_wb_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |-> !bus_wdata[RDY_BIT]);

    // R7: completion notice is a single-cycle pulse
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    // R8: a halted walker is silent
    p_fault_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!bus_req && !tx_start));

    // R8: the halt persists while enable stays high
    p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && enable) |=> fault);

    // R10: disabled walker issues no request
    p_off_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> !bus_req);

endmodule

// File: rtl/txbd_ring_walker.sv
module txbd_ring_walker
    import txbd_pkg::*;
#(
    parameter logic [31:0] RING_BASE = 32'h0000_1000,
    parameter int          IDX_W     = 7,
    parameter int          POLL_GAP  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    output logic        bus_req,
    output logic        bus_we,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic [31:0] bus_rdata,
    input  logic        bus_ack,
    input  logic        bus_err,
    output logic        tx_start,
    output logic [31:0] tx_buf_ptr,
    output logic [15:0] tx_len,
    output logic        tx_irq_req,
    output logic        tx_pad,
    output logic        tx_crc,
    input  logic        tx_done,
    output logic        done_pulse,
    output logic        fault
);

    logic [31:0] stat_addr;
    logic [31:0] ptr_addr;
    logic        advance;
    logic        wrap_last;
    logic        poll_load;
    logic        poll_expire;

    txbd_ring_index #(
        .RING_BASE (RING_BASE),
        .IDX_W     (IDX_W)
    ) index_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .wrap_last (wrap_last),
        .stat_addr (stat_addr),
        .ptr_addr  (ptr_addr)
    );

    txbd_poll_timer #(
        .POLL_GAP (POLL_GAP)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (poll_load),
        .expire (poll_expire)
    );

    txbd_walk_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .bus_rdata   (bus_rdata),
        .bus_ack     (bus_ack),
        .bus_err     (bus_err),
        .stat_addr   (stat_addr),
        .ptr_addr    (ptr_addr),
        .tx_done     (tx_done),
        .poll_expire (poll_expire),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .tx_start    (tx_start),
        .tx_buf_ptr  (tx_buf_ptr),
        .tx_len      (tx_len),
        .tx_irq_req  (tx_irq_req),
        .tx_pad      (tx_pad),
        .tx_crc      (tx_crc),
        .done_pulse  (done_pulse),
        .fault       (fault),
        .advance     (advance),
        .wrap_last   (wrap_last),
        .poll_load   (poll_load)
    );

endmodule

// File: tb/txbd_ring_walker_tb_top.sv
`timescale 1ns/1ps
module txbd_ring_walker_tb_top;

    localparam logic [31:0] BASE = 32'h0000_0400;
    localparam int GAP   = 5;
    localparam int SLOTS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;
    logic        bus_err = 1'b0;
    logic        tx_start;
    logic [31:0] tx_buf_ptr;
    logic [15:0] tx_len;
    logic        tx_irq_req, tx_pad, tx_crc;
    logic        tx_done = 1'b0;
    logic        done_pulse, fault;

    always #2.5 clk = ~clk;

    txbd_ring_walker #(
        .RING_BASE (BASE),
        .IDX_W     (4),
        .POLL_GAP  (GAP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
        .tx_start(tx_start), .tx_buf_ptr(tx_buf_ptr), .tx_len(tx_len),
        .tx_irq_req(tx_irq_req), .tx_pad(tx_pad), .tx_crc(tx_crc),
        .tx_done(tx_done), .done_pulse(done_pulse), .fault(fault)
    );

    int checks = 0;
    int fails  = 0;

    // Memory model state (mem written only by the stimulus process)
    logic [31:0] mem [0:15];
    logic        err_on = 1'b0;
    logic [31:0] err_addr = '0;
    int          rd_cnt = 0, wb_cnt = 0, req_cnt = 0, done_cnt = 0, start_cnt = 0;
    int          hold_viol = 0, idle_run = 0, last_gap = 0;
    logic [31:0] last_rd_addr = '0, wb_addr = '0, wb_data = '0;
    logic [31:0] wb_log [0:7];
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;
    logic        pend_we = 1'b0;

    always @(negedge clk) begin
        if (bus_req) req_cnt++;
        if (done_pulse) done_cnt++;
        if (!bus_req) idle_run++;
        else begin
            if (idle_run > 0) last_gap = idle_run;
            idle_run = 0;
        end
        if (pend && bus_req && !bus_ack && !bus_err &&
            (bus_addr != pend_addr || bus_we != pend_we)) hold_viol++;
        if (bus_ack || bus_err) begin
            bus_ack = 1'b0;
            bus_err = 1'b0;
            pend = 1'b0;
        end else if (bus_req) begin
            pend = 1'b1; pend_addr = bus_addr; pend_we = bus_we;
            if (err_on && bus_addr == err_addr) begin
                bus_err = 1'b1;
            end else begin
                bus_ack = 1'b1;
                if (bus_we) begin
                    wb_addr = bus_addr; wb_data = bus_wdata;
                    wb_log[wb_cnt % 8] = bus_addr;
                    wb_cnt++;
                end else begin
                    bus_rdata = mem[(bus_addr - BASE) >> 2 & 32'hF];
                    last_rd_addr = bus_addr;
                    rd_cnt++;
                end
            end
        end
    end

    // Engine model
    logic [31:0] cap_ptr = '0, cap_rd_addr = '0;
    logic [15:0] cap_len = '0;
    logic [2:0]  cap_flags = '0;
    int          dly = 0;
    always @(negedge clk) begin
        if (tx_done) tx_done = 1'b0;
        else if (tx_start) begin
            cap_ptr = tx_buf_ptr; cap_len = tx_len;
            cap_flags = {tx_irq_req, tx_pad, tx_crc};
            cap_rd_addr = last_rd_addr;
            start_cnt++;
            dly = 2 + (start_cnt % 4);
        end else if (dly > 0) begin
            dly--;
            if (dly == 0) tx_done = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic wait_rd(input logic [31:0] a, input string req);
        int n = 0;
        while (last_rd_addr != a && n < 400) begin @(negedge clk); n++; end
        chk(last_rd_addr == a, req, last_rd_addr, a);
    endtask

    task automatic wait_wb(input int target, input string req);
        int n = 0;
        while (wb_cnt < target && n < 400) begin @(negedge clk); n++; end
        chk(wb_cnt >= target, req, wb_cnt, target);
    endtask

    function automatic logic [31:0] mk_status(input int len, input int k, input bit wrap, input int low);
        logic [31:0] w;
        w = {16'(len), 16'h0};
        w[15] = 1'b1; w[14] = k[2]; w[13] = wrap; w[12] = k[1]; w[11] = k[0];
        w[10:0] = 11'(low);
        return w;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int s0, d0, w0;
        for (int i = 0; i < 16; i++) mem[i] = '0;
        for (int i = 0; i < SLOTS; i++) mem[2*i] = (i == SLOTS-1) ? 32'h0000_2000 : 32'h0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (10) @(negedge clk);
        // R1 / R10: quiet while disabled
        chk(!bus_req && !tx_start && !done_pulse && !fault, "R1 idle outputs", {bus_req, tx_start, done_pulse, fault}, 0);
        chk(req_cnt == 0, "R10 no requests while disabled", req_cnt, 0);

        // R3: polling a slot not owned by hardware
        @(posedge clk); #1 enable = 1'b1;
        repeat (40) @(negedge clk);
        chk(last_rd_addr == BASE, "R1 first read at ring base", last_rd_addr, BASE);
        chk(start_cnt == 0, "R3 no start for unowned slot", start_cnt, 0);
        chk(rd_cnt >= 4, "R3 repeated polling", rd_cnt, 4);
        chk(last_gap == GAP, "R3 poll idle gap", last_gap, GAP);

        // Sweep: four rounds over a ring of four slots
        for (int r = 0; r < 4; r++) begin
            for (int s = 0; s < SLOTS; s++) begin
                int k, len, nx;
                logic [31:0] st, pt, sa;
                k   = (r * 4 + s) % 8;
                len = 60 + r * 16 + s * 3;
                sa  = BASE + 32'(8 * s);
                st  = mk_status(len, k, s == SLOTS-1, r * 37 + s * 5 + 1);
                pt  = 32'h8000_0000 + 32'(s) * 32'h600 + 32'(r);
                wait_rd(sa, "R6 walker reached slot");
                @(posedge clk); #1;
                mem[2*s+1] = pt; mem[2*s] = st;
                s0 = start_cnt; d0 = done_cnt; w0 = wb_cnt;
                wait_wb(w0 + 1, "R5 write-back occurred");
                @(posedge clk); #1 mem[2*s] = wb_data;
                repeat (3) @(negedge clk);
                chk(cap_rd_addr == sa + 4, "R2 pointer read address", cap_rd_addr, sa + 4);
                chk(cap_ptr == pt, "R4 buffer pointer", cap_ptr, pt);
                chk(cap_len == 16'(len), "R4 frame length", 32'(cap_len), len);
                chk(cap_flags == 3'(k), "R4 irq/pad/crc flags", 32'(cap_flags), k);
                chk(start_cnt == s0 + 1, "R4 single start", start_cnt, s0 + 1);
                chk(wb_addr == sa, "R5 write-back address", wb_addr, sa);
                chk(wb_data == (st & ~32'h8000), "R5 write-back data", wb_data, st & ~32'h8000);
                chk(wb_cnt == w0 + 1, "R5 single write", wb_cnt, w0 + 1);
                chk(done_cnt == d0 + k / 4, "R7 completion pulse", done_cnt, d0 + k / 4);
                nx = (s == SLOTS-1) ? 0 : s + 1;
                wait_rd(BASE + 32'(8 * nx), "R6 next slot read");
            end
        end

        // Back-to-back: all four slots owned at once
        @(posedge clk); #1;
        for (int s = 0; s < SLOTS; s++) begin
            mem[2*s+1] = 32'h9000_0000 + 32'(s);
            mem[2*s]   = mk_status(100 + s, 1, s == SLOTS-1, 0);
        end
        w0 = wb_cnt;
        wait_wb(w0 + 4, "R6 four back-to-back releases");
        for (int s = 0; s < SLOTS; s++)
            chk(wb_log[(w0 + s) % 8] == BASE + 32'(8 * s), "R6 release order", wb_log[(w0 + s) % 8], BASE + 32'(8 * s));
        @(posedge clk); #1;
        for (int s = 0; s < SLOTS; s++) mem[2*s] = (s == SLOTS-1) ? 32'h0000_2000 : 32'h0;
        wait_rd(BASE, "R6 back at slot 0");

        // R8: bus error on the pointer read of slot 0
        @(posedge clk); #1;
        err_addr = BASE + 4; err_on = 1'b1;
        mem[1] = 32'hA000_0000; mem[0] = mk_status(77, 6, 1'b0, 3);
        s0 = start_cnt;
        repeat (30) @(negedge clk);
        chk(fault == 1'b1, "R8 fault raised", fault, 1);
        chk(start_cnt == s0, "R8 no start after error", start_cnt, s0);
        d0 = req_cnt;
        repeat (20) @(negedge clk);
        chk(req_cnt == d0, "R8 silent while halted", req_cnt, d0);
        @(posedge clk); #1 err_on = 1'b0; enable = 1'b0;
        repeat (3) @(negedge clk);
        chk(fault == 1'b0, "R8 fault cleared by disable", fault, 0);
        d0 = req_cnt;
        repeat (10) @(negedge clk);
        chk(req_cnt == d0, "R10 silent after disable", req_cnt, d0);
        w0 = wb_cnt;
        @(posedge clk); #1 enable = 1'b1;
        wait_wb(w0 + 1, "R8 resumed after re-enable");
        chk(wb_addr == BASE, "R8 resumed at same slot", wb_addr, BASE);
        chk(cap_ptr == 32'hA000_0000, "R8 resumed frame pointer", cap_ptr, 32'hA000_0000);

        // R10: disable while polling stops the walker
        @(posedge clk); #1 mem[0] = wb_data;
        repeat (20) @(negedge clk);
        @(posedge clk); #1 enable = 1'b0;
        repeat (GAP + 4) @(negedge clk);
        d0 = req_cnt;
        repeat (20) @(negedge clk);
        chk(req_cnt == d0, "R10 stopped after poll wait", req_cnt, d0);

        chk(hold_viol == 0, "R9 request held until response", hold_viol, 0);
        summary();
        $finish;
    end

endmodule